// File: doc/BRIEF.md
# FP32 Running-Sum Adder Stage

This block keeps a single-precision running sum. Each cycle in which the product strobe is high, the 32-bit floating-point word on the product input is added into an internal accumulator, and the new sum replaces the old one at the next clock edge. It is the back half of a multiply-accumulate pipeline: an upstream multiplier presents products, and this stage folds them into the total, one per cycle if needed.

The datapath compares the two operands by magnitude. It shifts the significand of the smaller one right until the exponents agree, then adds or subtracts the significands according to the signs. A leading-zero count or a single right shift brings the result back to normalized form. Rounding is by truncation. Results too small to normalize become zero. Results too large become a signed infinity. Two status bits record that either event has happened since the last clear.

A synchronous clear input returns the sum to +0 and drops both status bits. The accumulator value and the status bits come straight from registers.

Top module: `fp32_acc_stage`

## Requirements
- R1: Reset, or a high `clr_i` at a clock edge, sets the accumulator to 32'h0000_0000 and clears `ovf_o` and `udf_o`. A clear takes priority over a product strobed in the same cycle.
- R2: In a cycle with `prod_valid_i` low and `clr_i` low, the accumulator and both flags keep their values.
- R3: Before the add, the operand with the smaller magnitude has its 24-bit significand (hidden 1 followed by bits [22:0]) shifted right by the exponent difference (bits [30:23]). Bits shifted out are discarded. A difference of 25 or more leaves the larger operand unchanged.
- R4: When the signs (bit 31) match, the significands are added. A carry out of the top bit shifts the sum right by one place, discarding the low bit, and raises the exponent by one.
- R5: When the signs differ, the smaller significand is subtracted from the larger, and the result takes the sign of the larger-magnitude operand. An exact cancellation gives 32'h0000_0000 and sets no flag.
- R6: A difference whose leading 1 is below the hidden-bit position is shifted left until the leading 1 reaches that position. The exponent is lowered by the same count.
- R7: If that exponent would fall below 1, the result is 32'h0000_0000 and `udf_o` is set.
- R8: If a carry would push the exponent above 254, the result is a signed infinity (exponent 255, mantissa 0) and `ovf_o` is set.
- R9: `ovf_o` and `udf_o` stay set until a clear or a reset.
- R10: A product whose exponent field is 0 is treated as zero, and the accumulator is unchanged. When the accumulator is zero, a nonzero product is copied into it unchanged.
- R11: While the accumulator exponent is 255, products are ignored. When the accumulator is finite, a product with exponent 255 writes infinity with the product's sign and sets `ovf_o`.
- R12: The sum from a strobed product is visible on `acc_o` one cycle after the strobe. Products strobed on consecutive cycles each accumulate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous clear of sum and flags |
| prod_valid_i | input | 1 | Product strobe |
| prod_i | input | 32 | FP32 product word |
| acc_o | output | 32 | Accumulated FP32 sum |
| ovf_o | output | 1 | Sticky overflow flag |
| udf_o | output | 1 | Sticky underflow flag |

## Verification
The hardest case to reach is a subtraction that needs a long left shift and also underflows. This requires an accumulator sitting near the smallest normal exponent and a product of nearly equal magnitude and opposite sign. Directed vectors build such an accumulator on purpose, and then test that the flag persists through later sums. Random traffic keeps exponents inside a narrow band so that cancellation and carries happen often, and a behavioural integer model checks every cycle.

// File: rtl/fpacc_pkg.sv
package fpacc_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int SIG_W  = MAN_W + 1;
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int LZ_W   = $clog2(SIG_W + 1);

  typedef struct packed {
    logic             sgn;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } fp_t;
endpackage

// File: rtl/fp_align_unit.sv
module fp_align_unit
  import fpacc_pkg::*;
(
  input  fp_t              x_i,
  input  fp_t              y_i,
  output logic             big_sgn_o,
  output logic [EXP_W-1:0] big_exp_o,
  output logic [SIG_W-1:0] big_sig_o,
  output logic [SIG_W-1:0] sml_sig_o,
  output logic             sub_o
);
  localparam logic [EXP_W-1:0] DROP_SH = EXP_W'(SIG_W + 1);

  fp_t              big, sml;
  logic [EXP_W-1:0] diff;
  logic [SIG_W-1:0] sml_full;

  always_comb begin
    if ({x_i.exp, x_i.man} >= {y_i.exp, y_i.man}) begin
      big = x_i;
      sml = y_i;
    end else begin
      big = y_i;
      sml = x_i;
    end
    diff     = big.exp - sml.exp;
    sml_full = {1'b1, sml.man};
    sml_sig_o = (diff >= DROP_SH) ? '0 : (sml_full >> diff);
    big_sig_o = {1'b1, big.man};
    big_exp_o = big.exp;
    big_sgn_o = big.sgn;
    sub_o     = x_i.sgn ^ y_i.sgn;
  end
endmodule

// File: rtl/fp_lzc.sv
module fp_lzc #(
  parameter int W  = 24,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] zeros_o
);
  always_comb begin
    zeros_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) zeros_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fp_norm_unit.sv
module fp_norm_unit
  import fpacc_pkg::*;
(
  input  logic             big_sgn_i,
  input  logic [EXP_W-1:0] big_exp_i,
  input  logic [SIG_W-1:0] big_sig_i,
  input  logic [SIG_W-1:0] sml_sig_i,
  input  logic             sub_i,
  output fp_t              res_o,
  output logic             ovf_o,
  output logic             udf_o
);
  localparam int XW = EXP_W + 2;
  localparam logic [XW-1:0]    EXP_TOP = XW'((1 << EXP_W) - 1);
  localparam logic [EXP_W-1:0] E_INF   = '1;

  logic [SIG_W:0]   sum_w;
  logic [LZ_W-1:0]  lz;
  logic [XW-1:0]    e_ext, e_up, e_dn;
  logic [SIG_W-1:0] shifted;

  assign sum_w = sub_i ? ({1'b0, big_sig_i} - {1'b0, sml_sig_i})
                       : ({1'b0, big_sig_i} + {1'b0, sml_sig_i});

  fp_lzc #(.W(SIG_W), .CW(LZ_W)) u_lzc (
    .vec_i   (sum_w[SIG_W-1:0]),
    .zeros_o (lz)
  );

  assign e_ext   = XW'(big_exp_i);
  assign e_up    = e_ext + XW'(1);
  assign e_dn    = e_ext - XW'(lz);
  assign shifted = sum_w[SIG_W-1:0] << lz;

  always_comb begin
    res_o = '0;
    ovf_o = 1'b0;
    udf_o = 1'b0;
    if (sum_w == '0) begin
      res_o = '0;
    end else if (sum_w[SIG_W]) begin
      if (e_up >= EXP_TOP) begin
        ovf_o     = 1'b1;
        res_o.sgn = big_sgn_i;
        res_o.exp = E_INF;
      end else begin
        res_o.sgn = big_sgn_i;
        res_o.exp = e_up[EXP_W-1:0];
        res_o.man = sum_w[MAN_W:1];
      end
    end else if (XW'(lz) >= e_ext) begin
      udf_o = 1'b1;
    end else begin
      res_o.sgn = big_sgn_i;
      res_o.exp = e_dn[EXP_W-1:0];
      res_o.man = shifted[MAN_W-1:0];
    end
  end
endmodule

// File: rtl/fp32_acc_stage.sv
module fp32_acc_stage
  import fpacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              prod_valid_i,
  input  logic [WORD_W-1:0] prod_i,
  output logic [WORD_W-1:0] acc_o,
  output logic              ovf_o,
  output logic              udf_o
);
  localparam logic [EXP_W-1:0] E_INF = '1;

  fp_t              acc_q, prod, sum;
  logic             ovf_q, udf_q, sum_ovf, sum_udf;
  logic             a_sgn, a_sub;
  logic [EXP_W-1:0] a_exp;
  logic [SIG_W-1:0] a_big, a_sml;

  assign prod = fp_t'(prod_i);

  fp_align_unit u_align (
    .x_i       (acc_q),
    .y_i       (prod),
    .big_sgn_o (a_sgn),
    .big_exp_o (a_exp),
    .big_sig_o (a_big),
    .sml_sig_o (a_sml),
    .sub_o     (a_sub)
  );

  fp_norm_unit u_norm (
    .big_sgn_i (a_sgn),
    .big_exp_i (a_exp),
    .big_sig_i (a_big),
    .sml_sig_i (a_sml),
    .sub_i     (a_sub),
    .res_o     (sum),
    .ovf_o     (sum_ovf),
    .udf_o     (sum_udf)
  );

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else if (prod_valid_i) begin
      if (acc_q.exp == E_INF) begin
        acc_q <= acc_q;
      end else if (prod.exp == E_INF) begin
        acc_q <= '{sgn: prod.sgn, exp: E_INF, man: '0};
        ovf_q <= 1'b1;
      end else if (prod.exp == '0) begin
        acc_q <= acc_q;
      end else if (acc_q.exp == '0) begin
        acc_q <= prod;
      end else begin
        acc_q <= sum;
        ovf_q <= ovf_q | sum_ovf;
        udf_q <= udf_q | sum_udf;
      end
    end
  end

  assign acc_o = acc_q;
  assign ovf_o = ovf_q;
  assign udf_o = udf_q;

  a_r1_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (acc_q == '0 && !ovf_q && !udf_q));
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !prod_valid_i) |=> ($stable(acc_q) && $stable(ovf_q) && $stable(udf_q)));
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !clr_i) |=> ovf_q);
  a_r9_udf_sticky: assert property (@(posedge clk) disable iff (rst)
    (udf_q && !clr_i) |=> udf_q);
  a_r8_ovf_gives_inf: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> (acc_q.exp == E_INF && acc_q.man == '0));
  a_r7_udf_gives_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(udf_q) |-> (acc_q == '0));
  a_r5_zero_is_positive: assert property (@(posedge clk) disable iff (rst)
    (acc_q.exp == '0) |-> (acc_q == '0));
endmodule

// File: tb/tb_fp32_acc_stage.sv
module tb_fp32_acc_stage;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr_i = 1'b0;
  logic        prod_valid_i = 1'b0;
  logic [31:0] prod_i = '0;
  logic [31:0] acc_o;
  logic        ovf_o, udf_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_acc = '0;
  bit          m_ovf = 1'b0;
  bit          m_udf = 1'b0;

  always #10 clk = ~clk;

  fp32_acc_stage dut (
    .clk(clk), .rst(rst), .clr_i(clr_i), .prod_valid_i(prod_valid_i),
    .prod_i(prod_i), .acc_o(acc_o), .ovf_o(ovf_o), .udf_o(udf_o)
  );

  task automatic ref_update(input bit v, input bit c, input logic [31:0] p);
    logic [31:0] big, sml;
    longint bs, ss, r;
    int e, d;
    logic sg;
    if (c) begin
      m_acc = '0; m_ovf = 0; m_udf = 0;
    end else if (v) begin
      if (m_acc[30:23] == 8'hff) begin
      end else if (p[30:23] == 8'hff) begin
        m_acc = {p[31], 8'hff, 23'd0}; m_ovf = 1;
      end else if (p[30:23] == 8'h00) begin
      end else if (m_acc[30:23] == 8'h00) begin
        m_acc = p;
      end else begin
        if (m_acc[30:0] >= p[30:0]) begin big = m_acc; sml = p; end
        else begin big = p; sml = m_acc; end
        sg = big[31];
        bs = longint'({1'b1, big[22:0]});
        ss = longint'({1'b1, sml[22:0]});
        e  = int'(big[30:23]);
        d  = e - int'(sml[30:23]);
        ss = (d > 40) ? 0 : (ss >> d);
        r  = (m_acc[31] == p[31]) ? bs + ss : bs - ss;
        if (r == 0) begin
          m_acc = '0;
        end else if (r >= (longint'(1) << 24)) begin
          r = r >> 1; e = e + 1;
          if (e >= 255) begin m_acc = {sg, 8'hff, 23'd0}; m_ovf = 1; end
          else m_acc = {sg, e[7:0], r[22:0]};
        end else begin
          while (r < (longint'(1) << 23)) begin r = r << 1; e = e - 1; end
          if (e < 1) begin m_acc = '0; m_udf = 1; end
          else m_acc = {sg, e[7:0], r[22:0]};
        end
      end
    end
  endtask

  task automatic step(input bit v, input bit c, input logic [31:0] p, input string tag);
    prod_valid_i = v; clr_i = c; prod_i = p;
    @(posedge clk);
    ref_update(v, c, p);
    @(negedge clk);
    n_vec++;
    if (acc_o !== m_acc || ovf_o !== m_ovf || udf_o !== m_udf) begin
      n_bad++;
      $display("FAIL %s: acc=%h ovf=%b udf=%b expected acc=%h ovf=%b udf=%b",
               tag, acc_o, ovf_o, udf_o, m_acc, m_ovf, m_udf);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R12 watchdog: acc=%h expected run to finish", acc_o);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    prod_valid_i = 1'b1; prod_i = 32'h3f80_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; prod_valid_i = 1'b0;
    n_vec++;
    if (acc_o !== 32'h0 || ovf_o !== 1'b0 || udf_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: acc=%h ovf=%b udf=%b expected acc=00000000 ovf=0 udf=0",
               acc_o, ovf_o, udf_o);
    end
    // R10 zero-accumulator load, zero and exponent-0 products ignored
    step(1, 0, 32'h3f80_0000, "R10 load");
    step(1, 0, 32'h0000_0000, "R10 zero");
    step(1, 0, 32'h8000_0123, "R10 flushed");
    // R2 idle cycles
    step(0, 0, 32'h4000_0000, "R2 idle");
    step(0, 0, 32'h4000_0000, "R2 idle");
    // R4 carry and R12 back-to-back
    step(1, 0, 32'h3f80_0000, "R4 carry");
    step(1, 0, 32'h3fc0_0000, "R12 back2back");
    // R3 alignment, out of range and in range
    step(1, 0, 32'h3080_0000, "R3 far");
    step(1, 0, 32'h3580_0000, "R3 near");
    step(1, 0, 32'h3f80_0001, "R3 truncate");
    // R5 / R6 subtract and renormalize, exact cancellation
    step(0, 1, 32'h0, "R1 clear");
    step(1, 0, 32'h3f80_0000, "R10 load");
    step(1, 0, 32'hbf40_0000, "R6 renorm");
    step(1, 0, 32'hbe80_0000, "R5 cancel");
    step(1, 0, 32'h3f80_0000, "R10 load");
    step(1, 0, 32'hc040_0000, "R5 sign");
    // R7 underflow, R9 sticky
    step(0, 1, 32'h0, "R1 clear");
    step(1, 0, 32'h00c0_0000, "R10 load");
    step(1, 0, 32'h8080_0000, "R7 underflow");
    step(1, 0, 32'h3f80_0000, "R9 udf sticky");
    step(0, 0, 32'h0, "R9 udf sticky");
    step(0, 1, 32'h0, "R1 clear");
    // R8 overflow, R11 saturation hold
    step(1, 0, 32'h7f7f_ffff, "R10 load");
    step(1, 0, 32'h7f7f_ffff, "R8 overflow");
    step(1, 0, 32'hbf80_0000, "R11 hold");
    step(1, 0, 32'hff80_0000, "R11 hold");
    step(0, 1, 32'h0, "R1 clear");
    step(1, 0, 32'hff7f_ffff, "R10 load");
    step(1, 0, 32'hff7f_ffff, "R8 neg overflow");
    step(1, 1, 32'h3f80_0000, "R1 priority");
    step(1, 0, 32'h4000_0000, "R10 load");
    step(1, 0, 32'hff80_0000, "R11 inf product");
    step(0, 1, 32'h0, "R1 clear");
    step(1, 0, 32'h7fc0_0000, "R11 nan product");
    step(0, 1, 32'h0, "R1 clear");
    // mixed traffic
    for (int k = 0; k < 4000; k++) begin
      int unsigned rv;
      logic [7:0] ex;
      bit v, c;
      rv = $urandom;
      c  = (rv[5:0] == 6'd0);
      v  = (rv[7:6] != 2'd0);
      if (rv[11:8] == 4'd0) ex = 8'(rv[19:12]);
      else if (rv[11:8] == 4'd1) ex = 8'(1 + (rv[14:12]));
      else ex = 8'(124 + (rv[14:12] % 7));
      step(v, c, {rv[31], ex, 3'(rv[22:20]), 20'($urandom)}, "R3 R4 R5 R6 R12 mixed");
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule